// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and a calendar date in packed BCD registers: seconds, minutes, hours, day of month, month, a day-of-week counter and a two-digit year. A divider on the system clock produces one enable pulse per second. Each pulse advances the seconds and carries upward through the fields. The hours byte works in either a 24-hour or a 12-hour format with an afternoon flag. The date wraps at the true end of every month, and February has 29 days in years divisible by four.

A register bank on the host side writes one field per cycle through a load port. The load port is a valid/ready stream. `ld_ready` is always high, so the port never applies back-pressure, and a beat is taken in every cycle in which `ld_valid` is high. All seven fields are visible at the same time on the read outputs. The top bit of the seconds byte is a halt flag that freezes counting. Any write to the seconds field restarts the sub-second divider, so the next increment comes exactly one full second after the write.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour format), date 01, month 01, day-of-week 1, year 00, and the halt flag is clear.
- R2: Seconds (bits 6:0) and minutes count in BCD from 00 to 59. Seconds 59 wraps to 00 and advances minutes by one. Minutes 59 wraps to 00 when seconds also wrap.
- R3: With hours bit 7 = 0 (24-hour format), hours bits 5:0 count BCD 00 to 23. 23:59:59 rolls over to 00:00:00 and advances the date.
- R4: With hours bit 7 = 1 (12-hour format), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 1 to 12. 11:59:59 AM becomes 12:00:00 PM with the date unchanged. 12:59:59 becomes 01:00:00 with the same flag. 11:59:59 PM becomes 12:00:00 AM and advances the date.
- R5: At a day rollover, a date equal to the last day of its month goes to 01 and the month advances. April, June, September and November (BCD 04, 06, 09, 11) end on day 30, and every other month except February ends on day 31.
- R6: February ends on day 29 when the BCD year is divisible by four (00 counts as divisible) and on day 28 otherwise. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: Day-of-week advances by one at each midnight rollover and goes from 7 back to 1.
- R8: While seconds bit 7 (halt) is 1, no field changes unless loaded and `tick_o` stays low. Loading seconds with bit 7 = 0 resumes counting.
- R9: A load to the seconds field restarts the divider. The next increment lands on the clock edge TICK_DIV cycles after the load edge.
- R10: Load field codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day-of-week, 6 year. Code 7 changes nothing. A loaded field takes `ld_data` even when an increment falls in the same cycle, and the other fields still advance. `ld_ready` is always 1.
- R11: While running, `tick_o` is high for exactly one cycle in every TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted (always 1) |
| ld_field | input | 3 | Field code of the load |
| ld_data | input | 8 | BCD value to write |
| tick_o | output | 1 | One-second advance strobe |
| sec_o | output | 8 | Halt flag (bit 7) and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Format bit, PM or tens bit, BCD hours |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| dow_o | output | 8 | Day of week 1 to 7 |
| year_o | output | 8 | BCD year 00 to 99 |

## Verification
The assertions assume that the host writes only legal BCD values in range, and that the divider length is at least two, so that a seconds load can never coincide with a new tick. The stimulus respects both assumptions. Every field value the bench writes is a legal calendar value. To set a time, the bench first halts the counter with a seconds load, then writes the remaining fields, and writes seconds last. This leaves the divider at a known phase before any expected value is sampled. The one deliberate collision of a load with an increment is placed in the exact cycle in which the strobe is high.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned FIELD_W    = 3;
  localparam int unsigned BYTE_W     = 8;

  typedef enum logic [FIELD_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5,
    FLD_YEAR  = 3'd6
  } field_e;

  // Values after reset, seconds in the top byte down to year in the bottom byte.
  localparam logic [NUM_FIELDS*BYTE_W-1:0] RESET_FIELDS = 56'h00_00_00_01_01_01_00;

  // Increment a two-digit BCD byte. The caller handles the upper wrap.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // A two-digit BCD year is a multiple of four when:
  //   tens even and units in {0,4,8}, or
  //   tens odd and units in {2,6}.
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/sec_divider.sv
module sec_divider #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart)    cnt_q <= '0;
    else if (!halt)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  // A restart in the tick cycle wins, so no increment collides with a seconds write.
  assign tick = !halt && !restart && (cnt_q == LAST);
endmodule

// File: rtl/tod_next.sv
module tod_next
  import bcd_clock_pkg::*;
(
  input  logic [7:0] sec,
  input  logic [7:0] min,
  input  logic [7:0] hour,
  output logic [7:0] sec_n,
  output logic [7:0] min_n,
  output logic [7:0] hour_n,
  output logic       day_carry
);
  logic       s_wrap, m_wrap, h_day;
  logic [7:0] s_inc, h_step, h24_inc, h12_inc;

  always_comb begin
    s_wrap  = (sec[6:0] == 7'h59);
    m_wrap  = (min == 8'h59);
    s_inc   = bcd_inc({1'b0, sec[6:0]});
    h24_inc = bcd_inc(hour & 8'h7F);
    h12_inc = bcd_inc({3'b000, hour[4:0]});

    sec_n = s_wrap ? {sec[7], 7'h00} : ((s_inc & 8'h7F) | {sec[7], 7'h00});
    if (!s_wrap)     min_n = min;
    else if (m_wrap) min_n = 8'h00;
    else             min_n = bcd_inc(min);

    h_day = 1'b0;
    if (!hour[7]) begin
      if (hour[5:0] == 6'h23) begin
        h_step = 8'h00;
        h_day  = 1'b1;
      end else begin
        h_step = h24_inc & 8'h3F;
      end
    end else begin
      if (hour[4:0] == 5'h11) begin
        h_step = {2'b10, ~hour[5], 5'h12};
        h_day  = hour[5];
      end else if (hour[4:0] == 5'h12) begin
        h_step = {2'b10, hour[5], 5'h01};
      end else begin
        h_step = (h12_inc & 8'h1F) | {2'b10, hour[5], 5'b0};
      end
    end

    hour_n    = (s_wrap && m_wrap) ? h_step : hour;
    day_carry = s_wrap && m_wrap && h_day;
  end
endmodule

// File: rtl/date_next.sv
module date_next
  import bcd_clock_pkg::*;
(
  input  logic [7:0] date,
  input  logic [7:0] month,
  input  logic [7:0] dow,
  input  logic [7:0] year,
  input  logic       day_carry,
  output logic [7:0] date_n,
  output logic [7:0] month_n,
  output logic [7:0] dow_n,
  output logic [7:0] year_n
);
  logic [7:0] last_day;

  always_comb begin
    last_day = month_end(month, year_is_leap(year));
    date_n   = date;
    month_n  = month;
    year_n   = year;
    dow_n    = dow;
    if (day_carry) begin
      dow_n = (dow == 8'h07) ? 8'h01 : dow + 8'h01;
      if (date == last_day) begin
        date_n = 8'h01;
        if (month == 8'h12) begin
          month_n = 8'h01;
          year_n  = (year == 8'h99) ? 8'h00 : bcd_inc(year);
        end else begin
          month_n = bcd_inc(month);
        end
      end else begin
        date_n = bcd_inc(date);
      end
    end
  end
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [FIELD_W-1:0]   ld_field,
  input  logic [BYTE_W-1:0]    ld_data,
  output logic                 tick_o,
  output logic [BYTE_W-1:0]    sec_o,
  output logic [BYTE_W-1:0]    min_o,
  output logic [BYTE_W-1:0]    hour_o,
  output logic [BYTE_W-1:0]    date_o,
  output logic [BYTE_W-1:0]    month_o,
  output logic [BYTE_W-1:0]    dow_o,
  output logic [BYTE_W-1:0]    year_o
);
  logic [BYTE_W-1:0] cur [NUM_FIELDS];
  logic [BYTE_W-1:0] nxt [NUM_FIELDS];
  logic              tick, day_carry, sec_load;

  assign ld_ready = 1'b1;
  assign sec_load = ld_valid && (ld_field == FLD_SEC);

  sec_divider #(.TICK_DIV(TICK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt    (cur[FLD_SEC][7]),
    .restart (sec_load),
    .tick    (tick)
  );

  tod_next u_tod (
    .sec       (cur[FLD_SEC]),
    .min       (cur[FLD_MIN]),
    .hour      (cur[FLD_HOUR]),
    .sec_n     (nxt[FLD_SEC]),
    .min_n     (nxt[FLD_MIN]),
    .hour_n    (nxt[FLD_HOUR]),
    .day_carry (day_carry)
  );

  date_next u_date (
    .date      (cur[FLD_DATE]),
    .month     (cur[FLD_MONTH]),
    .dow       (cur[FLD_DOW]),
    .year      (cur[FLD_YEAR]),
    .day_carry (day_carry),
    .date_n    (nxt[FLD_DATE]),
    .month_n   (nxt[FLD_MONTH]),
    .dow_n     (nxt[FLD_DOW]),
    .year_n    (nxt[FLD_YEAR])
  );

  // One register per field. A load of that field beats the increment.
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam logic [BYTE_W-1:0] RST = RESET_FIELDS[(NUM_FIELDS-1-f)*BYTE_W +: BYTE_W];
    always_ff @(posedge clk) begin
      if (!rst_n)                                   cur[f] <= RST;
      else if (ld_valid && ld_field == FIELD_W'(f)) cur[f] <= ld_data;
      else if (tick)                                cur[f] <= nxt[f];
    end
  end

  assign tick_o  = tick;
  assign sec_o   = cur[FLD_SEC];
  assign min_o   = cur[FLD_MIN];
  assign hour_o  = cur[FLD_HOUR];
  assign date_o  = cur[FLD_DATE];
  assign month_o = cur[FLD_MONTH];
  assign dow_o   = cur[FLD_DOW];
  assign year_o  = cur[FLD_YEAR];
endmodule

// File: rtl/bcd_clock_core_chk.sv
module bcd_clock_core_chk #(
  parameter int unsigned TICK_DIV = 32768
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_valid,
  input logic [2:0] ld_field,
  input logic [7:0] ld_data,
  input logic       tick_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] dow_o,
  input logic [7:0] year_o
);
  logic [55:0] all_f;
  assign all_f = {sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o};

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !ld_valid) |=> $stable(all_f));

  p_halt_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[7] |-> !tick_o);

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !ld_valid) |=> $stable(all_f));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !ld_valid && sec_o[6:0] != 7'h59) |=> (sec_o[6:0] != $past(sec_o[6:0])));

  p_min_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_field == 3'd1) |=> (min_o == $past(ld_data)));

  p_date_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_field == 3'd3) |=> (date_o == $past(ld_data)));

  if (TICK_DIV > 1) begin : g_restart
    p_restart_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_field == 3'd0) |=> !tick_o);
  end
endmodule

bind bcd_clock_core bcd_clock_core_chk #(.TICK_DIV(TICK_DIV)) u_chk (.*);

// File: tb/bcd_clock_core_test.sv
module bcd_clock_core_test;
  localparam int CLK_NS = 10;
  localparam int DIV    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0;
  logic [2:0] ld_field = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic       ld_ready, tick_o;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o;

  int checks = 0;
  int errors = 0;
  int ticks_seen = 0;

  typedef struct { int req; logic [55:0] v; } exp_t;
  exp_t exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  bcd_clock_core #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_field(ld_field), .ld_data(ld_data), .tick_o(tick_o),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .dow_o(dow_o), .year_o(year_o)
  );

  // Monitor: pops the expected snapshots and compares them with the outputs.
  always @(negedge clk) begin
    #1;
    if (tick_o) ticks_seen++;
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [55:0] act;
      e = exp_q.pop_front();
      act = {sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o};
      checks++;
      if (act !== e.v) begin
        errors++;
        $display("FAIL R%0d: fields actual=%h expected=%h", e.req, act, e.v);
      end
    end
  end

  task automatic expect_cal(input int req, input logic [55:0] v);
    exp_q.push_back('{req, v});
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] f, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_field = f; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, m, h, dt, mo, dw, y);
    load(3'd0, 8'h80);
    load(3'd1, m); load(3'd2, h); load(3'd3, dt);
    load(3'd4, mo); load(3'd5, dw); load(3'd6, y);
    load(3'd0, s);
  endtask

  task automatic secs(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_cal(1, 56'h00_00_00_01_01_01_00);
    @(negedge clk);
    check_val("R10 ready", ld_ready, 1);

    // R2 seconds and minute carry
    set_all(8'h59, 8'h14, 8'h09, 8'h10, 8'h05, 8'h02, 8'h30);
    secs(1); expect_cal(2, 56'h00_15_09_10_05_02_30);
    // R3 tens of hours in 24-hour format
    set_all(8'h59, 8'h59, 8'h19, 8'h10, 8'h05, 8'h02, 8'h30);
    secs(1); expect_cal(3, 56'h00_00_20_10_05_02_30);
    // R3 R6 R7 full rollover at year end
    set_all(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
    secs(1); expect_cal(2, 56'h59_59_23_31_12_07_99);
    secs(1); expect_cal(6, 56'h00_00_00_01_01_01_00);

    // R4 twelve-hour format
    set_all(8'h59, 8'h59, 8'h91, 8'h15, 8'h03, 8'h03, 8'h24);
    secs(1); expect_cal(4, 56'h00_00_B2_15_03_03_24);
    set_all(8'h59, 8'h59, 8'hB1, 8'h15, 8'h03, 8'h03, 8'h24);
    secs(1); expect_cal(4, 56'h00_00_92_16_03_04_24);
    set_all(8'h59, 8'h59, 8'h92, 8'h16, 8'h03, 8'h04, 8'h24);
    secs(1); expect_cal(4, 56'h00_00_81_16_03_04_24);

    // R6 February lengths
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h05, 8'h24);
    secs(1); expect_cal(6, 56'h00_00_00_29_02_06_24);
    set_all(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h06, 8'h24);
    secs(1); expect_cal(6, 56'h00_00_00_01_03_07_24);
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h23);
    secs(1); expect_cal(6, 56'h00_00_00_01_03_03_23);
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h12);
    secs(1); expect_cal(6, 56'h00_00_00_29_02_03_12);
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h00);
    secs(1); expect_cal(6, 56'h00_00_00_29_02_03_00);

    // R5 thirty- and thirty-one-day months
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h01, 8'h21);
    secs(1); expect_cal(5, 56'h00_00_00_01_05_02_21);
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h01, 8'h21);
    secs(1); expect_cal(5, 56'h00_00_00_31_01_02_21);
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h11, 8'h01, 8'h21);
    secs(1); expect_cal(5, 56'h00_00_00_01_12_02_21);
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h09, 8'h01, 8'h21);
    secs(1); expect_cal(5, 56'h00_00_00_01_10_02_21);

    // R8 halt freezes everything, clearing resumes
    set_all(8'h10, 8'h30, 8'h08, 8'h05, 8'h06, 8'h02, 8'h21);
    load(3'd0, 8'h90);
    ticks_seen = 0;
    secs(3);
    expect_cal(8, 56'h90_30_08_05_06_02_21);
    @(negedge clk); #2;
    check_val("R8 ticks while halted", ticks_seen, 0);
    // R10 code 7 has no effect
    load(3'd7, 8'h33);
    expect_cal(10, 56'h90_30_08_05_06_02_21);
    load(3'd0, 8'h10);
    secs(1); expect_cal(8, 56'h11_30_08_05_06_02_21);

    // R9 divider restart on a seconds write
    load(3'd0, 8'h20);
    repeat (DIV - 1) @(negedge clk);
    expect_cal(9, 56'h20_30_08_05_06_02_21);
    @(negedge clk);
    expect_cal(9, 56'h21_30_08_05_06_02_21);
    // R11 one strobe per second
    load(3'd0, 8'h20);
    #2 ticks_seen = 0;
    secs(10); #2;
    check_val("R11 tick count", ticks_seen, 10);
    expect_cal(11, 56'h30_30_08_05_06_02_21);

    // R10 load beats the increment in the same cycle
    load(3'd0, 8'h05);
    repeat (DIV - 1) @(negedge clk);
    ld_valid = 1'b1; ld_field = 3'd1; ld_data = 8'h42;
    @(negedge clk);
    ld_valid = 1'b0;
    expect_cal(10, 56'h06_42_08_05_06_02_21);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule